// File: doc/BRIEF.md
# Trigger Path Event and Deadtime Counter Bank

This block watches a trigger path and keeps its statistics in one place. Three 32-bit counters record single-cycle strobes at the entry, middle and exit stages of the path. A fourth counter adds one for every clock cycle in which the deadtime level is high. A fifth counts orbit strobes, so software can turn the other counts into rates over a known number of turns. A per-bunch histogram keeps one counter per bunch-crossing slot. By default there are 3564 slots. Each exit-stage strobe adds one to the counter of the slot given on the bunch-crossing index input.

The register side has three controls. A freeze level stops every counter on the same clock edge, so all values read back belong to one instant. A clear pulse zeroes every counter and the whole histogram in a single cycle. A read port takes an address and returns the selected value on the next cycle. Histogram updates use read-modify-write on a RAM. A hit on the same slot in the very next cycle takes the freshly computed value through a bypass, so no count is lost.

Top module: `trig_stat_bank`

## Requirements
- R1: Each cycle in which `in_stb_i`, `mid_stb_i` or `out_stb_i` is high, with freeze and clear low, adds one to the entry, middle or exit stage counter respectively.
- R2: The deadtime counter adds one for every cycle in which `dead_i` is high, with freeze and clear low.
- R3: The turn counter adds one for every cycle in which `orbit_i` is high, with freeze and clear low.
- R4: A scalar counter that holds all ones stays at all ones on further events. It never wraps.
- R5: While `frz_i` is high, no event is counted. Scalar counters hold from the first frozen cycle. Histogram slots hold from the second frozen cycle.
- R6: A cycle with `clr_i` high sets all five scalar counters and every histogram slot to zero. Any event in that same cycle is discarded.
- R7: Each exit strobe with `bcid_i` below N_SLOTS adds one to that slot's histogram counter. The counter saturates at all ones of HIST_W bits.
- R8: Exit strobes on the same slot in consecutive cycles are each counted.
- R9: A read address given in cycle t appears on `rd_data_o` from the following cycle. Bit SLOT_W of the address set means a histogram read, with the slot index in the low bits, the result zero-extended, and slots at or above N_SLOTS reading 0. Bit SLOT_W clear selects a scalar by the low three bits: 0 entry, 1 middle, 2 exit, 3 deadtime, 4 turns, other codes 0. Strobes with `bcid_i` at or above N_SLOTS leave the histogram unchanged.
- R10: After reset every counter and histogram slot reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_stb_i | input | 1 | Entry-stage event strobe |
| mid_stb_i | input | 1 | Middle-stage event strobe |
| out_stb_i | input | 1 | Exit-stage (accept) strobe, also fills the histogram |
| dead_i | input | 1 | Deadtime level |
| orbit_i | input | 1 | Orbit strobe |
| bcid_i | input | SLOT_W | Bunch-crossing slot index of the current cycle |
| frz_i | input | 1 | Freeze level |
| clr_i | input | 1 | Clear pulse |
| rd_addr_i | input | SLOT_W+1 | Read address |
| rd_data_o | output | CNT_W | Read data, one cycle after the address |

## Verification
The hardest case to reach from the ports is a same-slot hit in the cycle right after another. Here the RAM read for the second hit returns the value from before the first write, and only the bypass keeps the count right. Random stimulus repeats the previous slot index about a quarter of the time. A directed burst then drives several consecutive accepts at one slot. Saturation is reached by building the bench with narrow counters and a short slot range, and running long enough to pass the top of the range.

// File: rtl/trig_stat_pkg.sv
package trig_stat_pkg;
  localparam int NUM_CTR = 5;

  typedef enum logic [2:0] {
    SEL_IN   = 3'd0,
    SEL_MID  = 3'd1,
    SEL_OUT  = 3'd2,
    SEL_DEAD = 3'd3,
    SEL_TURN = 3'd4
  } ctr_sel_e;
endpackage

// File: rtl/trig_stat_ctr.sv
module trig_stat_ctr #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (clr_i)              cnt_o <= '0;
    else if (inc_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/trig_stat_hist.sv
module trig_stat_hist #(
  parameter int N_SLOTS = 3564,
  parameter int SLOT_W  = 12,
  parameter int HIST_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              hit_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [HIST_W-1:0] rd_data_o
);
  logic [HIST_W-1:0] mem [N_SLOTS];
  logic [N_SLOTS-1:0] vld_q;

  logic              s1_hit_q, s1_vb_q;
  logic [SLOT_W-1:0] s1_slot_q;
  logic [HIST_W-1:0] s1_raw_q;
  logic              w_hit_q;
  logic [SLOT_W-1:0] w_slot_q;
  logic [HIST_W-1:0] w_val_q;
  logic [HIST_W-1:0] rd_raw_q;
  logic              rd_vb_q;

  logic [HIST_W-1:0] base, nxt;
  logic              fwd;

  // bypass the write committed on the previous edge
  always_comb begin
    fwd  = w_hit_q && (w_slot_q == s1_slot_q);
    base = fwd ? w_val_q : (s1_vb_q ? s1_raw_q : '0);
    nxt  = (base == '1) ? base : base + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (s1_hit_q && !clr_i) mem[s1_slot_q] <= nxt;
    s1_raw_q <= mem[slot_i];
    rd_raw_q <= mem[rd_slot_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= '0;
      s1_hit_q  <= 1'b0;
      s1_vb_q   <= 1'b0;
      s1_slot_q <= '0;
      w_hit_q   <= 1'b0;
      w_slot_q  <= '0;
      w_val_q   <= '0;
      rd_vb_q   <= 1'b0;
    end else begin
      s1_hit_q  <= hit_i && !clr_i;
      s1_slot_q <= slot_i;
      s1_vb_q   <= vld_q[slot_i];
      w_hit_q   <= s1_hit_q && !clr_i;
      w_slot_q  <= s1_slot_q;
      w_val_q   <= nxt;
      rd_vb_q   <= vld_q[rd_slot_i];
      if (clr_i)         vld_q <= '0;
      else if (s1_hit_q) vld_q[s1_slot_q] <= 1'b1;
    end
  end

  assign rd_data_o = rd_vb_q ? rd_raw_q : '0;
endmodule

// File: rtl/trig_stat_bank.sv
module trig_stat_bank
  import trig_stat_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int HIST_W  = 16,
  parameter int N_SLOTS = 3564,
  parameter int SLOT_W  = $clog2(N_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_stb_i,
  input  logic              mid_stb_i,
  input  logic              out_stb_i,
  input  logic              dead_i,
  input  logic              orbit_i,
  input  logic [SLOT_W-1:0] bcid_i,
  input  logic              frz_i,
  input  logic              clr_i,
  input  logic [SLOT_W:0]   rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o
);
  logic [NUM_CTR-1:0] ev;
  logic [CNT_W-1:0]   cnt [NUM_CTR];

  assign ev[SEL_IN]   = in_stb_i;
  assign ev[SEL_MID]  = mid_stb_i;
  assign ev[SEL_OUT]  = out_stb_i;
  assign ev[SEL_DEAD] = dead_i;
  assign ev[SEL_TURN] = orbit_i;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    trig_stat_ctr #(.W(CNT_W)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_i),
      .inc_i (ev[g] && !frz_i),
      .cnt_o (cnt[g])
    );
  end

  logic              bc_ok, rd_ok;
  logic [SLOT_W-1:0] bc_slot, rd_slot;
  logic [HIST_W-1:0] hist_rd;

  assign bc_ok   = 32'(bcid_i) < N_SLOTS;
  assign rd_ok   = 32'(rd_addr_i[SLOT_W-1:0]) < N_SLOTS;
  assign bc_slot = bc_ok ? bcid_i : '0;
  assign rd_slot = rd_ok ? rd_addr_i[SLOT_W-1:0] : '0;

  trig_stat_hist #(
    .N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .HIST_W(HIST_W)
  ) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .hit_i    (out_stb_i && bc_ok && !frz_i && !clr_i),
    .slot_i   (bc_slot),
    .rd_slot_i(rd_slot),
    .rd_data_o(hist_rd)
  );

  logic             rd_hist_q, rd_ok_q;
  logic [CNT_W-1:0] rd_scal_q;
  logic [2:0]       sel;

  assign sel = rd_addr_i[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_hist_q <= 1'b0;
      rd_ok_q   <= 1'b0;
      rd_scal_q <= '0;
    end else begin
      rd_hist_q <= rd_addr_i[SLOT_W];
      rd_ok_q   <= rd_ok;
      rd_scal_q <= (32'(sel) < NUM_CTR) ? cnt[sel] : '0;
    end
  end

  assign rd_data_o = rd_hist_q ? (rd_ok_q ? CNT_W'(hist_rd) : '0) : rd_scal_q;
endmodule

// File: rtl/trig_stat_bank_chk.sv
module trig_stat_bank_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frz_i,
  input logic             clr_i,
  input logic             dead_i,
  input logic [CNT_W-1:0] c_in,
  input logic [CNT_W-1:0] c_dead,
  input logic [CNT_W-1:0] c_turn
);
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (c_in - $past(c_in)) <= CNT_W'(1)); // R1

  AST_DEAD_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dead_i && !frz_i && !clr_i && c_dead != '1) |=> c_dead == $past(c_dead) + 1'b1); // R2

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_in == '1 && !clr_i) |=> c_in == '1); // R4

  AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_i && !clr_i) |=> ($stable(c_in) && $stable(c_dead) && $stable(c_turn))); // R5

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (c_in == '0 && c_dead == '0 && c_turn == '0)); // R6
endmodule

bind trig_stat_bank trig_stat_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .frz_i (frz_i),
  .clr_i (clr_i),
  .dead_i(dead_i),
  .c_in  (cnt[0]),
  .c_dead(cnt[3]),
  .c_turn(cnt[4])
);

// File: tb/trig_stat_bank_tb_top.sv
module trig_stat_bank_tb_top;
  localparam int CW = 8;
  localparam int HW = 4;
  localparam int NS = 20;
  localparam int SW = 5;
  localparam int CMAX = (1 << CW) - 1;
  localparam int HMAX = (1 << HW) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_stb_i = 0, mid_stb_i = 0, out_stb_i = 0, dead_i = 0, orbit_i = 0;
  logic frz_i = 0, clr_i = 0;
  logic [SW-1:0] bcid_i = '0;
  logic [SW:0]   rd_addr_i = '0;
  logic [CW-1:0] rd_data_o;

  int checks = 0, errors = 0;
  int e_cnt [5];
  int e_hist [32];
  bit done = 0;

  always #2 clk_i = ~clk_i;

  trig_stat_bank #(.CNT_W(CW), .HIST_W(HW), .N_SLOTS(NS), .SLOT_W(SW)) dut_i (
    .clk_i, .rst_ni, .in_stb_i, .mid_stb_i, .out_stb_i, .dead_i, .orbit_i,
    .bcid_i, .frz_i, .clr_i, .rd_addr_i, .rd_data_o
  );

  function automatic int sat_inc(int v, int mx);
    return (v >= mx) ? mx : v + 1;
  endfunction

  // one cycle of stimulus, model follows the requirements
  task automatic step(bit i, bit m, bit o, bit d, bit t, int bc, bit f, bit c);
    @(negedge clk_i);
    in_stb_i = i; mid_stb_i = m; out_stb_i = o; dead_i = d; orbit_i = t;
    bcid_i = SW'(bc); frz_i = f; clr_i = c;
    if (c) begin
      foreach (e_cnt[k]) e_cnt[k] = 0;
      foreach (e_hist[k]) e_hist[k] = 0;
    end else if (!f) begin
      if (i) e_cnt[0] = sat_inc(e_cnt[0], CMAX);
      if (m) e_cnt[1] = sat_inc(e_cnt[1], CMAX);
      if (o) e_cnt[2] = sat_inc(e_cnt[2], CMAX);
      if (d) e_cnt[3] = sat_inc(e_cnt[3], CMAX);
      if (t) e_cnt[4] = sat_inc(e_cnt[4], CMAX);
      if (o && bc < NS) e_hist[bc] = sat_inc(e_hist[bc], HMAX);
    end
  endtask

  task automatic check(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic rd(int addr, int exp, string req);
    @(negedge clk_i);
    rd_addr_i = (SW+1)'(addr);
    @(posedge clk_i);
    #1;
    check(int'(rd_data_o), exp, req, $sformatf("addr %0d", addr));
  endtask

  // freeze, let the pipeline drain, then read every counter and slot
  task automatic read_all(string base);
    string tags [5];
    tags[0] = "R1"; tags[1] = "R1"; tags[2] = "R1"; tags[3] = "R2"; tags[4] = "R3";
    repeat (3) step(0, 0, 0, 0, 0, 0, 1, 0);
    for (int k = 0; k < 5; k++)
      rd(k, e_cnt[k], (base != "") ? base : ((e_cnt[k] == CMAX) ? "R4" : tags[k]));
    rd(6, 0, "R9");
    for (int s = 0; s < 32; s++)
      rd((1 << SW) | s, (s < NS) ? e_hist[s] : 0,
         (base != "") ? base : ((s < NS) ? "R7" : "R9"));
  endtask

  task automatic rand_run(int n);
    int prev = 0;
    for (int k = 0; k < n; k++) begin
      int bc;
      bc = ($urandom % 4 == 0) ? prev : int'($urandom % 32);
      prev = bc;
      step($urandom % 2 == 0, $urandom % 3 == 0, $urandom % 2 == 0,
           $urandom % 3 != 0, $urandom % 8 == 0, bc, 0, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    foreach (e_cnt[k]) e_cnt[k] = 0;
    foreach (e_hist[k]) e_hist[k] = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    read_all("R10");

    rand_run(200);
    read_all("");

    rand_run(400);           // pushes narrow counters past their tops
    read_all("");
    check(e_cnt[0], CMAX, "R4", "model reached saturation");

    // clear with every event in the same cycle
    step(1, 1, 1, 1, 1, 3, 0, 1);
    read_all("R6");

    // consecutive accepts on one slot, then a gap and one more
    for (int k = 0; k < 6; k++) step(0, 0, 1, 0, 0, 7, 0, 0);
    step(0, 0, 0, 0, 0, 7, 0, 0);
    step(0, 0, 1, 0, 0, 7, 0, 0);
    step(0, 0, 1, 0, 0, 8, 0, 0);
    step(0, 0, 1, 0, 0, 7, 0, 0);
    read_all("R8");

    // events while frozen are dropped
    rand_run(30);
    for (int k = 0; k < 12; k++) step(1, 1, 1, 1, 1, k, 1, 0);
    read_all("R5");

    // out-of-range slot indices leave the histogram alone
    for (int k = 0; k < 10; k++) step(0, 0, 1, 0, 0, NS + k, 0, 0);
    read_all("R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule